// File: doc/BRIEF.md
# Trace Packet Encapsulating Slicer

This block takes one trace message at a time from a trace encoder and wraps it in an encapsulation frame. The frame starts with a one-byte header holding the payload length, a two-bit flow selector and an extend flag. An optional timestamp of a fixed number of bytes follows the header, and the payload of 1 to 31 bytes comes last. The assembled frame is then cut into fixed-width slices that are written one per cycle into a downstream FIFO. Each slice comes with a count of its valid bytes, so a trace bus transmitter can forward it unchanged.

Bytes go out starting from the least significant byte of the frame, so the header byte leaves first. The input is a valid/ready port. Once a frame is taken, the block holds ready low until the frame's last slice has been written. A full FIFO freezes the current slice in place. A message with length zero is taken and thrown away, because length zero marks null frames and this block never produces them.

Top module: `trace_pkt_slicer`

## Requirements
- R1: Byte 0 of the first slice of every frame is the header: bits [4:0] hold the accepted `in_len`, bits [6:5] hold `cfg_flow` and bit [7] holds the extend flag.
- R2: The extend flag is 1 exactly when `in_ts_en` was high at acceptance and TS_BYTES > 0. In that case frame bytes 1..TS_BYTES carry `in_ts`, least significant byte first. Otherwise no timestamp byte is sent.
- R3: The payload bytes follow directly after the header, or after the timestamp when one is present, least significant byte first. Only `in_len` bytes are sent. Any byte position beyond the end of the frame in the final slice reads as zero.
- R4: Slice k carries frame bytes k*SLICE_BYTES upward, with the lowest frame byte in bits [7:0]. A frame of N = 1 + T*extend + L bytes takes ceil(N/SLICE_BYTES) writes. `out_wr` is high in every busy cycle in which `fifo_full` is low.
- R5: `out_nbytes_m1` equals the number of valid bytes in the slice minus one. It is SLICE_BYTES-1 for every slice except possibly the last.
- R6: While `fifo_full` is high, `out_wr` stays low and `out_data` and `out_nbytes_m1` stay unchanged.
- R7: `in_ready` falls in the cycle after a nonzero-length frame is accepted. It stays low until the cycle after that frame's last slice is written, and it is high whenever the block is idle.
- R8: A message accepted with `in_len` = 0 produces no slice, and `in_ready` stays high.
- R9: After reset, `in_ready` is high and `out_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Block can take a message |
| in_payload | input | 248 | Payload bytes, byte 0 in bits [7:0] |
| in_len | input | 5 | Payload length in bytes |
| in_ts | input | TS_BYTES*8 (8 if 0) | Timestamp value |
| in_ts_en | input | 1 | Include the timestamp in this frame |
| cfg_flow | input | 2 | Flow selector copied into the header |
| out_wr | output | 1 | FIFO write strobe |
| out_data | output | SLICE_BYTES*8 | Slice data |
| out_nbytes_m1 | output | max(1,log2(SLICE_BYTES)) | Valid bytes in slice minus one |
| fifo_full | input | 1 | Downstream FIFO is full |

## Verification
A wrong remaining-byte count shows up at the first partial slice. The byte count is wrong there, and `in_ready` comes back early or late, so the next frame's header lands in the wrong write. A shift register that is out of step corrupts the very next written slice: a byte ends up duplicated or skipped in the scoreboard comparison. A stall that fails to hold state shows as changed `out_data` on the second full cycle. A header built with the wrong extend or length is visible in the cycle right after acceptance, before any write takes place.

// File: rtl/trace_pkt_pkg.sv
package trace_pkt_pkg;
   localparam int PAY_BYTES = 31;
   localparam int PAY_W     = PAY_BYTES * 8;

   typedef struct packed {
      logic       ext;
      logic [1:0] flow;
      logic [4:0] len;
   } encap_hdr_t;
endpackage

// File: rtl/tps_hdr_builder.sv
module tps_hdr_builder
   import trace_pkt_pkg::*;
#(
   parameter int TS_BYTES = 8
) (
   input  logic [4:0]  len,
   input  logic [1:0]  flow,
   input  logic        ts_en,
   output encap_hdr_t  hdr
);
   logic ext_bit;

   if (TS_BYTES == 0) begin : g_no_ts
      assign ext_bit = 1'b0;
   end else begin : g_ts
      assign ext_bit = ts_en;
   end

   assign hdr = '{ext: ext_bit, flow: flow, len: len};
endmodule

// File: rtl/tps_packer.sv
module tps_packer
   import trace_pkt_pkg::*;
#(
   parameter int TS_BYTES = 8,
   parameter int BUF_W    = 320,
   parameter int CNT_W    = 6,
   localparam int TS_W    = (TS_BYTES > 0) ? TS_BYTES * 8 : 8
) (
   input  encap_hdr_t         hdr,
   input  logic [PAY_W-1:0]   payload,
   input  logic [TS_W-1:0]    ts,
   output logic [BUF_W-1:0]   pkt_bits,
   output logic [CNT_W-1:0]   pkt_bytes
);
   logic [PAY_W-1:0] pay_m;

   for (genvar b = 0; b < PAY_BYTES; b++) begin : g_mask
      assign pay_m[b*8 +: 8] = (hdr.len > 5'(b)) ? payload[b*8 +: 8] : 8'h00;
   end

   if (TS_BYTES == 0) begin : g_plain
      always_comb begin
         pkt_bits          = '0;
         pkt_bits[7:0]     = hdr;
         pkt_bits[8 +: PAY_W] = pay_m;
      end
      assign pkt_bytes = CNT_W'(1) + CNT_W'(hdr.len);
   end else begin : g_stamped
      always_comb begin
         pkt_bits      = '0;
         pkt_bits[7:0] = hdr;
         if (hdr.ext) begin
            pkt_bits[8 +: TS_W]         = ts;
            pkt_bits[8 + TS_W +: PAY_W] = pay_m;
         end else begin
            pkt_bits[8 +: PAY_W] = pay_m;
         end
      end
      assign pkt_bytes = CNT_W'(1) + (hdr.ext ? CNT_W'(TS_BYTES) : CNT_W'(0))
                       + CNT_W'(hdr.len);
   end
endmodule

// File: rtl/tps_slice_engine.sv
module tps_slice_engine #(
   parameter int SLICE_BYTES = 4,
   parameter int BUF_W       = 320,
   parameter int CNT_W       = 6,
   localparam int SLICE_W    = SLICE_BYTES * 8,
   localparam int NB_W       = (SLICE_BYTES > 1) ? $clog2(SLICE_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [BUF_W-1:0]   load_bits,
   input  logic [CNT_W-1:0]   load_bytes,
   input  logic               fifo_full,
   output logic               busy,
   output logic               out_wr,
   output logic [SLICE_W-1:0] out_data,
   output logic [NB_W-1:0]    out_nbytes_m1
);
   logic [BUF_W-1:0] sh_q;
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] cur_bytes;
   logic             last_slice;

   assign last_slice = rem_q <= CNT_W'(SLICE_BYTES);
   assign cur_bytes  = last_slice ? rem_q : CNT_W'(SLICE_BYTES);
   assign out_wr     = busy && !fifo_full;
   assign out_data   = sh_q[SLICE_W-1:0];
   assign out_nbytes_m1 = NB_W'(cur_bytes - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         rem_q <= '0;
         sh_q  <= '0;
      end else if (load) begin
         busy  <= 1'b1;
         rem_q <= load_bytes;
         sh_q  <= load_bits;
      end else if (out_wr) begin
         sh_q  <= sh_q >> SLICE_W;
         rem_q <= last_slice ? '0 : rem_q - CNT_W'(SLICE_BYTES);
         if (last_slice) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/trace_pkt_slicer.sv
module trace_pkt_slicer
   import trace_pkt_pkg::*;
#(
   parameter int SLICE_BYTES = 4,
   parameter int TS_BYTES    = 8,
   localparam int TS_W       = (TS_BYTES > 0) ? TS_BYTES * 8 : 8,
   localparam int SLICE_W    = SLICE_BYTES * 8,
   localparam int NB_W       = (SLICE_BYTES > 1) ? $clog2(SLICE_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [PAY_W-1:0]   in_payload,
   input  logic [4:0]         in_len,
   input  logic [TS_W-1:0]    in_ts,
   input  logic               in_ts_en,
   input  logic [1:0]         cfg_flow,
   output logic               out_wr,
   output logic [SLICE_W-1:0] out_data,
   output logic [NB_W-1:0]    out_nbytes_m1,
   input  logic               fifo_full
);
   localparam int PKT_MAX    = 1 + TS_BYTES + PAY_BYTES;
   localparam int SLICES_MAX = (PKT_MAX + SLICE_BYTES - 1) / SLICE_BYTES;
   localparam int BUF_W      = SLICES_MAX * SLICE_W;
   localparam int CNT_W      = $clog2(PKT_MAX + 1);

   if (SLICE_BYTES < 1 || SLICE_BYTES > 16 || (SLICE_BYTES & (SLICE_BYTES - 1)) != 0) begin : g_bad_slice
      $error("SLICE_BYTES must be a power of two from 1 to 16");
   end
   if (TS_BYTES < 0 || TS_BYTES > 8) begin : g_bad_ts
      $error("TS_BYTES must lie in 0..8");
   end

   encap_hdr_t       hdr;
   logic [BUF_W-1:0] pkt_bits;
   logic [CNT_W-1:0] pkt_bytes;
   logic             busy;
   logic             load;

   tps_hdr_builder #(.TS_BYTES(TS_BYTES)) u_hdr (
      .len   (in_len),
      .flow  (cfg_flow),
      .ts_en (in_ts_en),
      .hdr   (hdr)
   );

   tps_packer #(.TS_BYTES(TS_BYTES), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_pack (
      .hdr       (hdr),
      .payload   (in_payload),
      .ts        (in_ts),
      .pkt_bits  (pkt_bits),
      .pkt_bytes (pkt_bytes)
   );

   assign in_ready = !busy;
   assign load     = in_valid && in_ready && (in_len != 5'd0);

   tps_slice_engine #(.SLICE_BYTES(SLICE_BYTES), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_eng (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (load),
      .load_bits     (pkt_bits),
      .load_bytes    (pkt_bytes),
      .fifo_full     (fifo_full),
      .busy          (busy),
      .out_wr        (out_wr),
      .out_data      (out_data),
      .out_nbytes_m1 (out_nbytes_m1)
   );
endmodule

// File: rtl/trace_pkt_slicer_chk.sv
module trace_pkt_slicer_chk #(
   parameter int SLICE_BYTES = 4,
   parameter int TS_BYTES    = 8,
   localparam int SLICE_W    = SLICE_BYTES * 8,
   localparam int NB_W       = (SLICE_BYTES > 1) ? $clog2(SLICE_BYTES) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic [4:0]         in_len,
   input logic               in_ts_en,
   input logic [1:0]         cfg_flow,
   input logic               out_wr,
   input logic [SLICE_W-1:0] out_data,
   input logic [NB_W-1:0]    out_nbytes_m1,
   input logic               fifo_full
);
   localparam logic TS_ON = (TS_BYTES > 0);

   // R1 and R2: header byte right after acceptance
   assert_header_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_len != 5'd0) |=>
      (out_data[7:0] == {($past(in_ts_en) && TS_ON), $past(cfg_flow), $past(in_len)}));

   assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !out_wr);

   assert_slice_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !in_ready) |=> ($stable(out_data) && $stable(out_nbytes_m1)));

   assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_len != 5'd0) |=> !in_ready);

   assert_zero_len_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_len == 5'd0) |=> (in_ready && !out_wr));

   assert_partial_is_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_wr && out_nbytes_m1 != NB_W'(SLICE_BYTES - 1)) |=> in_ready);

   assert_idle_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_wr);
endmodule

bind trace_pkt_slicer trace_pkt_slicer_chk #(.SLICE_BYTES(SLICE_BYTES), .TS_BYTES(TS_BYTES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .in_len        (in_len),
   .in_ts_en      (in_ts_en),
   .cfg_flow      (cfg_flow),
   .out_wr        (out_wr),
   .out_data      (out_data),
   .out_nbytes_m1 (out_nbytes_m1),
   .fifo_full     (fifo_full)
);

// File: tb/test_trace_pkt_slicer.sv
`timescale 1ns/1ps
module test_trace_pkt_slicer;
   localparam int SB   = 4;
   localparam int TB   = 8;
   localparam int SW   = SB * 8;
   localparam int NBW  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [247:0]    in_payload = '0;
   logic [4:0]      in_len = '0;
   logic [TB*8-1:0] in_ts = '0;
   logic            in_ts_en = 1'b0;
   logic [1:0]      cfg_flow = '0;
   logic            out_wr;
   logic [SW-1:0]   out_data;
   logic [NBW-1:0]  out_nbytes_m1;
   logic            fifo_full = 1'b0;

   int errors = 0;
   int checks = 0;
   bit full_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   logic [SW-1:0]  exp_data_q[$];
   logic [NBW-1:0] exp_nb_q[$];

   always #4 clk = ~clk;

   trace_pkt_slicer #(.SLICE_BYTES(SB), .TS_BYTES(TB)) i_trace_pkt_slicer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_payload(in_payload), .in_len(in_len), .in_ts(in_ts), .in_ts_en(in_ts_en),
      .cfg_flow(cfg_flow), .out_wr(out_wr), .out_data(out_data),
      .out_nbytes_m1(out_nbytes_m1), .fifo_full(fifo_full)
   );

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   // Backpressure generator, driven between edges
   always @(posedge clk) begin
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fifo_full = full_mode && lfsr[0];
   end

   // Monitor: scoreboard pop on each write, stall hold check
   logic [SW-1:0]  held_data;
   logic [NBW-1:0] held_nb;
   bit             was_stall = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (was_stall && !in_ready) begin
            check(out_data == held_data && out_nbytes_m1 == held_nb,
                  "R6 slice held during full", 64'(out_data), 64'(held_data));
         end
         if (out_wr) begin
            if (fifo_full) check(1'b0, "R6 write while full", 1, 0);
            if (exp_data_q.size() == 0) begin
               check(1'b0, "R8 unexpected slice", 64'(out_data), 0);
            end else begin
               logic [SW-1:0]  ed;
               logic [NBW-1:0] en;
               ed = exp_data_q.pop_front();
               en = exp_nb_q.pop_front();
               check(out_data == ed, "R3 R4 slice data", 64'(out_data), 64'(ed));
               check(out_nbytes_m1 == en, "R5 valid byte count", 64'(out_nbytes_m1), 64'(en));
            end
         end
         was_stall = fifo_full && !in_ready;
         held_data = out_data;
         held_nb   = out_nbytes_m1;
      end
   end

   task automatic send_pkt(input int len, input bit ts_en, input logic [1:0] flow);
      logic [7:0] fb[64];
      int n;
      logic [247:0] pay;
      logic [63:0]  ts;
      logic [7:0]   hdr;
      for (int w = 0; w < 8; w++) pay[w*32 +: 32] = $urandom;
      pay[247:224] = 24'($urandom);
      ts  = {$urandom, $urandom};
      hdr = {ts_en, flow, 5'(len)};
      fb[0] = hdr;
      n = 1;
      if (ts_en) for (int i = 0; i < TB; i++) begin fb[n] = ts[i*8 +: 8]; n++; end
      for (int i = 0; i < len; i++) begin fb[n] = pay[i*8 +: 8]; n++; end
      if (len != 0) begin
         for (int s = 0; s * SB < n; s++) begin
            logic [SW-1:0] d;
            int v;
            d = '0;
            for (int j = 0; j < SB; j++) if (s*SB + j < n) d[j*8 +: 8] = fb[s*SB + j];
            v = (n - s*SB < SB) ? n - s*SB : SB;
            exp_data_q.push_back(d);
            exp_nb_q.push_back(NBW'(v - 1));
         end
      end
      @(posedge clk); #2;
      in_valid = 1'b1; in_len = 5'(len); in_ts_en = ts_en; cfg_flow = flow;
      in_payload = pay; in_ts = ts;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk); #2;
      in_valid = 1'b0;
      in_payload = {8{32'hDEADBEEF}};
      @(negedge clk);
      if (len != 0) begin
         check(!in_ready, "R7 ready low after accept", 64'(in_ready), 0);
         check(out_data[7:0] == hdr, "R1 R2 header byte", 64'(out_data[7:0]), 64'(hdr));
      end else begin
         check(in_ready && !out_wr, "R8 zero length dropped", 64'({in_ready, out_wr}), 64'b10);
      end
   endtask

   task automatic drain();
      int t = 0;
      while ((exp_data_q.size() != 0 || !in_ready) && t < 2000) begin
         @(negedge clk); t++;
      end
      repeat (3) @(negedge clk);
      check(exp_data_q.size() == 0, "R4 all slices written", 64'(exp_data_q.size()), 0);
      check(in_ready, "R7 ready back when idle", 64'(in_ready), 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R9 reset ready", 64'(in_ready), 1);
      check(out_wr == 1'b0, "R9 reset no write", 64'(out_wr), 0);

      send_pkt(1, 1'b1, 2'd2);  drain();   // R2 timestamp present, 10 bytes
      send_pkt(31, 1'b1, 2'd1); drain();   // 40 bytes, all full slices
      send_pkt(5, 1'b0, 2'd3);  drain();   // R3 6 bytes, partial slice
      send_pkt(3, 1'b0, 2'd0);  drain();   // exactly one slice
      send_pkt(0, 1'b1, 2'd1);  drain();   // R8
      send_pkt(2, 1'b1, 2'd0);             // back to back
      send_pkt(7, 1'b0, 2'd1);  drain();

      full_mode = 1'b1;                    // R6 random backpressure
      for (int l = 0; l < 32; l++) begin
         send_pkt(l, l[0], 2'(l));
      end
      drain();
      full_mode = 1'b0;
      send_pkt(30, 1'b1, 2'd3); drain();

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule